// File: doc/BRIEF.md
# Two-Wire Bus Segment Link Sequencer

This block decides when the upstream and downstream segments of a two-wire bus buffer are joined. It samples SDA and SCL on both segments through synchronizer chains. For each segment it detects STOP conditions and measures how long the segment has been quiet. A state machine combines these observations with an enable input, a power-good input and a disconnect request from an external stuck-bus timer. It drives a link command for the analog pass switch, a ready flag and a permit for the rise-time accelerators.

The segments are joined only at a safe point in the traffic. That point is reached when both segments are quiet, or when one segment has just finished a transfer with a STOP while the other is quiet. This way a transaction already under way on either side is never cut into. A fresh enable edge overrides this rule while the disconnect request is held. Software can then rejoin a stuck bus on purpose. All time constants are parameters counted in system clock cycles.

Top module: `seg_link_seq`

## Requirements
- R1: After reset, link_o, ready_o and accel_ok_o are all low.
- R2: While pwr_good_i is low, all SDA/SCL activity is ignored, both quiet counters are held at zero, and link_o is low from the first clock edge that samples pwr_good_i low.
- R3: A segment counts as quiet once its synchronized SDA and SCL have both been high for IDLE_CYCLES consecutive cycles. A low level on either line restarts that segment's own count.
- R4: With enable high and power good, the segments are joined (link_o high) one clock edge after both segments are quiet.
- R5: The segments are also joined one edge after a STOP is seen on one segment while the other segment is quiet. A STOP is a synchronized SDA rising edge while synchronized SCL is high.
- R6: When en_i is sampled low, link_o, ready_o and accel_ok_o are low after that edge. When en_i returns high, the block waits for the R4/R5 condition again.
- R7: ready_o is high exactly when link_o is high. It is never high while en_i or pwr_good_i was low at the previous edge.
- R8: accel_ok_o rises one cycle after link_o rises and falls on the same edge as link_o.
- R9: A rising edge of fault_disc_i while joined breaks the link and drops ready_o on the next edge. The link stays broken while the request is held. After the request clears, the block rejoins through the R4/R5 condition.
- R10: When en_i goes high while fault_disc_i is high, the segments are joined on the next edge, whatever the bus levels.
- R11: Each bus input passes through SYNC_STAGES flops before it is used. With both segments released together from a busy state, link_o rises on the edge SYNC_STAGES + IDLE_CYCLES + 1 after the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Link enable, synchronous to clk |
| pwr_good_i | input | 1 | Supply good; low means undervoltage lockout |
| fault_disc_i | input | 1 | Disconnect request from the stuck-bus timer |
| up_sda_i | input | 1 | Upstream SDA level (asynchronous) |
| up_scl_i | input | 1 | Upstream SCL level (asynchronous) |
| dn_sda_i | input | 1 | Downstream SDA level (asynchronous) |
| dn_scl_i | input | 1 | Downstream SCL level (asynchronous) |
| link_o | output | 1 | Close the pass switch between segments |
| ready_o | output | 1 | Registered active-high ready flag |
| accel_ok_o | output | 1 | Rise-time accelerators may be enabled |

## Verification
The bench builds the block with IDLE_CYCLES = 12 and SYNC_STAGES = 2 instead of the roughly 19000-cycle quiet time used in service. At that size the exact edge on which a quiet segment becomes eligible can be pinned down and compared against a STOP-driven join that lands well before the quiet count completes. The short window also lets lockout, enable cycling, fault disconnect with reconnection, and the forced rejoin on a stuck bus all run back to back. A behavioural model is compared with all three outputs on every cycle.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
   typedef enum logic [2:0] {
      ST_LOCK = 3'd0,
      ST_OFF  = 3'd1,
      ST_ARM  = 3'd2,
      ST_LINK = 3'd3,
      ST_FLT  = 3'd4
   } lnk_state_e;
endpackage

// File: rtl/lnk_sync.sv
module lnk_sync #(
   parameter int STAGES = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("lnk_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      genvar i;
      for (i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= RST_VAL;
               else        chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= RST_VAL;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lnk_side_mon.sv
module lnk_side_mon #(
   parameter int IDLE_CYCLES = 19000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   input  logic sda_i,
   input  logic scl_i,
   output logic stop_o,
   output logic idle_o
);
   localparam int CW = $clog2(IDLE_CYCLES + 1);
   localparam logic [CW-1:0] CMAX = CW'(IDLE_CYCLES);

   generate
      if (IDLE_CYCLES < 1) begin : g_bad
         $error("lnk_side_mon: IDLE_CYCLES must be at least 1");
      end
   endgenerate

   logic sda_s, scl_s, sda_prev_q;
   logic [CW-1:0] quiet_cnt_q;

   lnk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));
   lnk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sda_prev_q  <= 1'b1;
         quiet_cnt_q <= '0;
      end else begin
         sda_prev_q <= sda_s;
         if (hold_i || !sda_s || !scl_s) quiet_cnt_q <= '0;
         else if (quiet_cnt_q != CMAX)   quiet_cnt_q <= quiet_cnt_q + 1'b1;
      end
   end

   assign stop_o = sda_s && !sda_prev_q && scl_s;
   assign idle_o = (quiet_cnt_q == CMAX);

   // R3: quiet only if both lines were high at the previous edge
   assert_idle_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
      idle_o |-> $past(sda_s) && $past(scl_s) && !$past(hold_i));
   // R2: lockout clears the quiet count
   assert_hold_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> !idle_o);
endmodule

// File: rtl/lnk_fsm.sv
module lnk_fsm
   import lnk_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic pwr_good_i,
   input  logic fault_i,
   input  logic up_stop_i,
   input  logic up_idle_i,
   input  logic dn_stop_i,
   input  logic dn_idle_i,
   output logic link_o,
   output logic ready_o,
   output logic accel_ok_o
);
   lnk_state_e st_q, st_n;
   logic fault_q, join_ok, link_q, ready_q, accel_q;

   assign join_ok = (up_idle_i && dn_idle_i) ||
                    (up_stop_i && dn_idle_i) ||
                    (dn_stop_i && up_idle_i);

   always_comb begin
      st_n = st_q;
      if (!pwr_good_i) st_n = ST_LOCK;
      else begin
         unique case (st_q)
            ST_LOCK: st_n = en_i ? ST_ARM : ST_OFF;
            ST_OFF:  if (en_i) st_n = fault_i ? ST_LINK : ST_ARM;
            ST_ARM:  if (!en_i) st_n = ST_OFF;
                     else if (join_ok) st_n = ST_LINK;
            ST_LINK: if (!en_i) st_n = ST_OFF;
                     else if (fault_i && !fault_q) st_n = ST_FLT;
            ST_FLT:  if (!en_i) st_n = ST_OFF;
                     else if (!fault_i) st_n = ST_ARM;
            default: st_n = ST_LOCK;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_LOCK;
         fault_q <= 1'b0;
         link_q  <= 1'b0;
         ready_q <= 1'b0;
         accel_q <= 1'b0;
      end else begin
         st_q    <= st_n;
         fault_q <= fault_i;
         link_q  <= (st_n == ST_LINK);
         ready_q <= (st_n == ST_LINK) && en_i && pwr_good_i;
         accel_q <= (st_q == ST_LINK) && (st_n == ST_LINK);
      end
   end

   assign link_o     = link_q;
   assign ready_o    = ready_q;
   assign accel_ok_o = accel_q;

   assert_lockout_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good_i |=> !link_o);
   assert_en_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !link_o && !ready_o && !accel_ok_o);
   assert_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_o) |-> $past(en_i) && $past(pwr_good_i));
   assert_accel_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(accel_ok_o) |-> $past(link_o));
   assert_join_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_o) |-> $past(join_ok) || $past(fault_i));
   assert_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (link_o && en_i && pwr_good_i && fault_i && !fault_q) |=> !link_o);
endmodule

// File: rtl/seg_link_seq.sv
module seg_link_seq #(
   parameter int IDLE_CYCLES = 19000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic pwr_good_i,
   input  logic fault_disc_i,
   input  logic up_sda_i,
   input  logic up_scl_i,
   input  logic dn_sda_i,
   input  logic dn_scl_i,
   output logic link_o,
   output logic ready_o,
   output logic accel_ok_o
);
   localparam int NSIDE = 2;

   logic [NSIDE-1:0] sda_v, scl_v, stop_v, idle_v;
   assign sda_v = {dn_sda_i, up_sda_i};
   assign scl_v = {dn_scl_i, up_scl_i};

   generate
      genvar s;
      for (s = 0; s < NSIDE; s++) begin : g_side
         lnk_side_mon #(.IDLE_CYCLES(IDLE_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_mon (
            .clk(clk), .rst_n(rst_n), .hold_i(!pwr_good_i),
            .sda_i(sda_v[s]), .scl_i(scl_v[s]),
            .stop_o(stop_v[s]), .idle_o(idle_v[s]));
      end
   endgenerate

   lnk_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .pwr_good_i(pwr_good_i),
      .fault_i(fault_disc_i),
      .up_stop_i(stop_v[0]), .up_idle_i(idle_v[0]),
      .dn_stop_i(stop_v[1]), .dn_idle_i(idle_v[1]),
      .link_o(link_o), .ready_o(ready_o), .accel_ok_o(accel_ok_o));

   assert_ready_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> link_o);
endmodule

// File: tb/seg_link_seq_bench.sv
module seg_link_seq_bench;
   localparam int IDLE = 12;
   localparam int SYN  = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic en = 1'b1, pg = 1'b0, flt = 1'b0;
   logic usda = 1'b1, uscl = 1'b1, dsda = 1'b1, dscl = 1'b1;
   logic link, rdy, acc;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   seg_link_seq #(.IDLE_CYCLES(IDLE), .SYNC_STAGES(SYN)) u_seg_link_seq (
      .clk(clk), .rst_n(rst_n), .en_i(en), .pwr_good_i(pg), .fault_disc_i(flt),
      .up_sda_i(usda), .up_scl_i(uscl), .dn_sda_i(dsda), .dn_scl_i(dscl),
      .link_o(link), .ready_o(rdy), .accel_ok_o(acc));

   // behavioural reference model
   bit qus[$], quc[$], qds[$], qdc[$];
   int m_cnt_u, m_cnt_d, m_state; // 0 lock 1 off 2 arm 3 link 4 fault-held
   bit m_prev_u, m_prev_d, m_fq, m_link, m_acc;

   task automatic model_reset();
      qus = {1'b1, 1'b1}; quc = {1'b1, 1'b1}; qds = {1'b1, 1'b1}; qdc = {1'b1, 1'b1};
      m_cnt_u = 0; m_cnt_d = 0; m_state = 0;
      m_prev_u = 1; m_prev_d = 1; m_fq = 0; m_link = 0; m_acc = 0;
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         bit su, cu, sd, cd, stop_u, stop_d, idle_u, idle_d, ok;
         int nx;
         su = qus[0]; cu = quc[0]; sd = qds[0]; cd = qdc[0];
         stop_u = su && !m_prev_u && cu;
         stop_d = sd && !m_prev_d && cd;
         idle_u = (m_cnt_u == IDLE);
         idle_d = (m_cnt_d == IDLE);
         ok = (idle_u && idle_d) || (stop_u && idle_d) || (stop_d && idle_u);
         nx = m_state;
         if (!pg) nx = 0;
         else if (m_state == 0) nx = en ? 2 : 1;
         else if (m_state == 1) begin if (en) nx = flt ? 3 : 2; end
         else if (!en) nx = 1;
         else if (m_state == 2) begin if (ok) nx = 3; end
         else if (m_state == 3) begin if (flt && !m_fq) nx = 4; end
         else if (m_state == 4) begin if (!flt) nx = 2; end
         m_acc = (m_state == 3) && (nx == 3);
         m_link = (nx == 3);
         m_state = nx;
         m_fq = flt;
         m_prev_u = su; m_prev_d = sd;
         if (!pg || !su || !cu) m_cnt_u = 0; else if (m_cnt_u < IDLE) m_cnt_u++;
         if (!pg || !sd || !cd) m_cnt_d = 0; else if (m_cnt_d < IDLE) m_cnt_d++;
         void'(qus.pop_front()); qus.push_back(usda);
         void'(quc.pop_front()); quc.push_back(uscl);
         void'(qds.pop_front()); qds.push_back(dsda);
         void'(qdc.pop_front()); qdc.push_back(dscl);
      end
   end

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R4/R5 link vs model", int'(link), int'(m_link));
         chk("R7 ready vs model", int'(rdy), int'(m_link));
         chk("R8 accel vs model", int'(acc), int'(m_acc));
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      chk("R1 link", int'(link), 0); chk("R1 ready", int'(rdy), 0); chk("R1 accel", int'(acc), 0);

      // R2: lockout with bus busy then quiet
      usda = 0; step(5); usda = 1; step(40);
      chk("R2 lockout link", int'(link), 0);

      // R3/R4: power good with quiet bus
      pg = 1; step(IDLE);
      chk("R3 not yet quiet", int'(link), 0);
      step(4);
      chk("R4 join when both quiet", int'(link), 1);
      chk("R7 ready with link", int'(rdy), 1);
      chk("R8 accel after link", int'(acc), 1);

      // R6: enable low
      en = 0; step(1);
      chk("R6 link off", int'(link), 0); chk("R6 ready off", int'(rdy), 0); chk("R6 accel off", int'(acc), 0);

      // R5: upstream busy, then STOP
      uscl = 0; usda = 0; step(3); en = 1; step(30);
      chk("R3 busy side blocks", int'(link), 0);
      uscl = 1; step(3); usda = 1; step(2);
      chk("R5 not before STOP seen", int'(link), 0);
      step(3);
      chk("R5 join on STOP", int'(link), 1);

      // R9: fault disconnect and reconnect
      flt = 1; step(2);
      chk("R9 link broken", int'(link), 0); chk("R9 ready low", int'(rdy), 0);
      step(30);
      chk("R9 held while request", int'(link), 0);
      flt = 0; step(3);
      chk("R9 rejoin via quiet", int'(link), 1);

      // R10: forced join on stuck bus
      dscl = 0; flt = 1; step(2);
      chk("R9 stuck disconnect", int'(link), 0);
      en = 0; step(3); en = 1; step(1);
      chk("R10 forced join", int'(link), 1);
      step(1);
      chk("R10 accel after forced", int'(acc), 1);

      // R11: exact sync + quiet latency
      dscl = 1; flt = 0; step(2);
      en = 0; uscl = 0; dscl = 0; step(3); en = 1; step(20);
      uscl = 1; dscl = 1;
      step(SYN + IDLE);
      chk("R11 one edge early", int'(link), 0);
      step(1);
      chk("R11 exact join edge", int'(link), 1);

      // R2: power lost while joined
      pg = 0; step(1);
      chk("R2 lockout breaks link", int'(link), 0);
      chk("R7 ready drops", int'(rdy), 0);
      step(2);
      finish_run();
   end
endmodule